// File: doc/BRIEF.md
# Permission-Checked Address Translation Buffer

This block is a small, fully associative translation buffer. It sits beside a load/store path and turns a 32-bit virtual address into a physical address. The lookup compares the virtual page number against every entry at once. Each entry stores a page mapping together with present, read-permission and write-permission flags, and two usage flags: touched and dirty. The buffer does not walk page tables in hardware. A lookup ends in exactly one of three results: a hit that returns the physical address, a miss, or a protection fault. Software services a miss or a fault.

Pages are 4 KB, so the lowest 12 address bits pass through unchanged. The upper 20 bits select the page. A successful access marks its entry as touched, and a successful write also marks it dirty. Software can clear every touched bit at once, which lets it keep an approximate least-recently-used order. Software can also load a chosen entry by index or drop all mappings in one cycle. These maintenance operations take effect only while the privileged-mode input is high. In user mode each attempt is discarded and flagged as a privilege fault.

Top module: `vxlate_tlb`

## Requirements
- R1: Every request accepted on a clock edge with reqValid high produces rspValid high exactly one cycle later, and rspValid is low in every other cycle.
- R2: While rspValid is high, exactly one of rspHit, rspMiss and rspFault is high; while it is low, all three are low.
- R3: On a hit, rspPaddr equals the matching entry's physical page number concatenated above the request's address bits [11:0]. On a miss or a fault, rspPaddr is zero.
- R4: A request whose address bits [31:12] equal the page number of no present entry gives a miss.
- R5: Access type reqWrite=0 is a read and needs the entry's read permission; reqWrite=1 is a write and needs write permission. A matching request without the needed permission gives a fault and changes neither usage flag.
- R6: A hit sets the entry's touched flag, and rspWasTouched reports that flag as it stood before the access. clearTouched clears every touched flag, except that a hit in the same cycle leaves its own entry touched.
- R7: A write hit sets the entry's dirty flag, and rspWasDirty reports that flag as it stood before the access. Read hits and faults leave it unchanged.
- R8: flushAll clears every present flag in one cycle. A load in the same cycle is discarded.
- R9: A privileged load writes page number, physical page number, present, read and write flags into the entry at updIndex, and clears that entry's touched and dirty flags.
- R10: With privMode low, updValid, flushAll and clearTouched have no effect on the stored entries, and privFault goes high in the next cycle. privFault is low after any cycle without such an attempt.
- R11: When several present entries hold the same page number, the entry with the lowest index answers.
- R12: A lookup in the same cycle as a load sees the contents from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 32 | Virtual address of the request |
| reqWrite | input | 1 | Access type: 1 for write, 0 for read |
| privMode | input | 1 | High when the issuer runs privileged |
| updValid | input | 1 | Load one entry |
| updIndex | input | 4 | Entry slot to load |
| updVpn | input | 20 | Virtual page number to store |
| updPpn | input | 20 | Physical page number to store |
| updPresent | input | 1 | Present flag to store |
| updRead | input | 1 | Read permission to store |
| updWrite | input | 1 | Write permission to store |
| flushAll | input | 1 | Clear all present flags |
| clearTouched | input | 1 | Clear all touched flags |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspHit | output | 1 | Translation succeeded |
| rspMiss | output | 1 | No present entry matched |
| rspFault | output | 1 | Matching entry lacks the needed permission |
| rspPaddr | output | 32 | Physical address on a hit |
| rspWasTouched | output | 1 | Touched flag before this hit |
| rspWasDirty | output | 1 | Dirty flag before this hit |
| privFault | output | 1 | A maintenance attempt was made in user mode |

## Verification
The bench builds the buffer with 4 entries and a 20-bit physical page number. With only 4 entries, its pool of 8 random page numbers keeps overwriting slots. This produces misses, replacements and duplicate mappings often. Duplicates exercise the lowest-index rule. Frequent overwrites make flush, clear and load collide with lookups in the same cycle. Each collision checks the ordering rules for pre-load contents, flush priority and touched-bit retention.

// File: rtl/vxlate_pkg.sv
package vxlate_pkg;

  // Strobes from the control unit to the entry store.
  typedef struct packed {
    logic load;        // write one entry at the update index
    logic flush;       // drop every present flag
    logic clrTouched;  // clear every touched flag
    logic mark;        // set touched on the matching entry
    logic markDirty;   // set dirty on the matching entry
  } tlbStrobe_t;

endpackage

// File: rtl/vxlate_store.sv
module vxlate_store
  import vxlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [VPN_W-1:0] lookVpn,
  input  logic [IDX_W-1:0] updIndex,
  input  logic [VPN_W-1:0] updVpn,
  input  logic [PPN_W-1:0] updPpn,
  input  logic             updPresent,
  input  logic             updRead,
  input  logic             updWrite,
  output logic             matchAny,
  output logic [PPN_W-1:0] matchPpn,
  output logic             matchRd,
  output logic             matchWr,
  output logic             matchTouched,
  output logic             matchDirty
);

  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] rdVec;
  logic [ENTRIES-1:0] wrVec;
  logic [ENTRIES-1:0] touchVec;
  logic [ENTRIES-1:0] dirtyVec;
  logic [VPN_W-1:0]   vpnTab [ENTRIES];
  logic [PPN_W-1:0]   ppnTab [ENTRIES];
  logic [ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]   matchIdx;

  // Parallel compare, one comparator per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g] = validVec[g] && (vpnTab[g] == lookVpn);
  end

  // Lowest index wins among duplicate mappings.
  always_comb begin
    matchAny = 1'b0;
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        matchAny = 1'b1;
        matchIdx = IDX_W'(i);
      end
    end
  end

  assign matchPpn     = ppnTab[matchIdx];
  assign matchRd      = rdVec[matchIdx];
  assign matchWr      = wrVec[matchIdx];
  assign matchTouched = touchVec[matchIdx];
  assign matchDirty   = dirtyVec[matchIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
      rdVec    <= '0;
      wrVec    <= '0;
      touchVec <= '0;
      dirtyVec <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnTab[i] <= '0;
        ppnTab[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.flush) begin
          validVec[i] <= 1'b0;
        end else if (strobe.load && updIndex == IDX_W'(i)) begin
          validVec[i] <= updPresent;
        end
        if (strobe.load && updIndex == IDX_W'(i)) begin
          vpnTab[i]   <= updVpn;
          ppnTab[i]   <= updPpn;
          rdVec[i]    <= updRead;
          wrVec[i]    <= updWrite;
          touchVec[i] <= 1'b0;
          dirtyVec[i] <= 1'b0;
        end else begin
          touchVec[i] <= (touchVec[i] & ~strobe.clrTouched)
                       | (strobe.mark && matchIdx == IDX_W'(i));
          dirtyVec[i] <= dirtyVec[i]
                       | (strobe.markDirty && matchIdx == IDX_W'(i));
        end
      end
    end
  end

  // R8: a flush strobe leaves no present entry behind.
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (validVec == '0));

endmodule

// File: rtl/vxlate_ctrl.sv
module vxlate_ctrl
  import vxlate_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  parameter int PA_W      = PPN_W + PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [PAGE_BITS-1:0] reqOffset,
  input  logic                 reqWrite,
  input  logic                 privMode,
  input  logic                 updValid,
  input  logic                 flushAll,
  input  logic                 clearTouched,
  input  logic                 matchAny,
  input  logic [PPN_W-1:0]     matchPpn,
  input  logic                 matchRd,
  input  logic                 matchWr,
  input  logic                 matchTouched,
  input  logic                 matchDirty,
  output tlbStrobe_t           strobe,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic                 rspMiss,
  output logic                 rspFault,
  output logic [PA_W-1:0]      rspPaddr,
  output logic                 rspWasTouched,
  output logic                 rspWasDirty,
  output logic                 privFault
);

  logic permitted;
  logic isHit;
  logic isMiss;
  logic isFault;
  logic userTry;

  assign permitted = reqWrite ? matchWr : matchRd;
  assign isHit     = reqValid && matchAny && permitted;
  assign isFault   = reqValid && matchAny && !permitted;
  assign isMiss    = reqValid && !matchAny;
  assign userTry   = !privMode && (updValid || flushAll || clearTouched);

  always_comb begin
    strobe.flush      = flushAll && privMode;
    strobe.load       = updValid && privMode && !flushAll;
    strobe.clrTouched = clearTouched && privMode;
    strobe.mark       = isHit;
    strobe.markDirty  = isHit && reqWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspHit        <= 1'b0;
      rspMiss       <= 1'b0;
      rspFault      <= 1'b0;
      rspPaddr      <= '0;
      rspWasTouched <= 1'b0;
      rspWasDirty   <= 1'b0;
      privFault     <= 1'b0;
    end else begin
      rspValid      <= reqValid;
      rspHit        <= isHit;
      rspMiss       <= isMiss;
      rspFault      <= isFault;
      rspPaddr      <= isHit ? {matchPpn, reqOffset} : '0;
      rspWasTouched <= isHit && matchTouched;
      rspWasDirty   <= isHit && matchDirty;
      privFault     <= userTry;
    end
  end

  // R1: one cycle from request to response.
  p_rsp_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R2: exactly one outcome per response.
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspHit, rspMiss, rspFault}) == 1);
  p_no_outcome_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspHit || rspMiss || rspFault));
  // R3: page offset carried through from the request.
  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (!rspHit || rspPaddr[PAGE_BITS-1:0] == $past(reqOffset)));

endmodule

// File: rtl/vxlate_tlb.sv
module vxlate_tlb
  import vxlate_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int PA_W     = PPN_W + PAGE_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             privMode,
  input  logic             updValid,
  input  logic [IDX_W-1:0] updIndex,
  input  logic [VPN_W-1:0] updVpn,
  input  logic [PPN_W-1:0] updPpn,
  input  logic             updPresent,
  input  logic             updRead,
  input  logic             updWrite,
  input  logic             flushAll,
  input  logic             clearTouched,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspMiss,
  output logic             rspFault,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspWasTouched,
  output logic             rspWasDirty,
  output logic             privFault
);

  tlbStrobe_t       strobe;
  logic             matchAny;
  logic [PPN_W-1:0] matchPpn;
  logic             matchRd;
  logic             matchWr;
  logic             matchTouched;
  logic             matchDirty;

  vxlate_ctrl #(
    .PAGE_BITS(PAGE_BITS),
    .PPN_W    (PPN_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqOffset    (reqVaddr[PAGE_BITS-1:0]),
    .reqWrite     (reqWrite),
    .privMode     (privMode),
    .updValid     (updValid),
    .flushAll     (flushAll),
    .clearTouched (clearTouched),
    .matchAny     (matchAny),
    .matchPpn     (matchPpn),
    .matchRd      (matchRd),
    .matchWr      (matchWr),
    .matchTouched (matchTouched),
    .matchDirty   (matchDirty),
    .strobe       (strobe),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspMiss      (rspMiss),
    .rspFault     (rspFault),
    .rspPaddr     (rspPaddr),
    .rspWasTouched(rspWasTouched),
    .rspWasDirty  (rspWasDirty),
    .privFault    (privFault)
  );

  vxlate_store #(
    .ENTRIES(ENTRIES),
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .lookVpn      (reqVaddr[VA_W-1:PAGE_BITS]),
    .updIndex     (updIndex),
    .updVpn       (updVpn),
    .updPpn       (updPpn),
    .updPresent   (updPresent),
    .updRead      (updRead),
    .updWrite     (updWrite),
    .matchAny     (matchAny),
    .matchPpn     (matchPpn),
    .matchRd      (matchRd),
    .matchWr      (matchWr),
    .matchTouched (matchTouched),
    .matchDirty   (matchDirty)
  );

  // R10: user-mode attempts never reach the entry store.
  p_user_blocked_r10: assert property (@(posedge clk) disable iff (!rstN)
    !privMode |-> !(strobe.load || strobe.flush || strobe.clrTouched));

endmodule

// File: tb/vxlate_tlb_bench.sv
module vxlate_tlb_bench;

  localparam int ENT  = 4;
  localparam int IDXW = 2;
  localparam int PPNW = 20;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [31:0]     reqVaddr = '0;
  logic            reqWrite = 1'b0;
  logic            privMode = 1'b0;
  logic            updValid = 1'b0;
  logic [IDXW-1:0] updIndex = '0;
  logic [19:0]     updVpn = '0;
  logic [PPNW-1:0] updPpn = '0;
  logic            updPresent = 1'b0;
  logic            updRead = 1'b0;
  logic            updWrite = 1'b0;
  logic            flushAll = 1'b0;
  logic            clearTouched = 1'b0;
  logic            rspValid, rspHit, rspMiss, rspFault;
  logic [31:0]     rspPaddr;
  logic            rspWasTouched, rspWasDirty, privFault;

  int total = 0;
  int bad = 0;

  // Reference model state.
  logic            mValid [ENT];
  logic [19:0]     mVpn   [ENT];
  logic [PPNW-1:0] mPpn   [ENT];
  logic            mRd    [ENT];
  logic            mWr    [ENT];
  logic            mTouch [ENT];
  logic            mDirty [ENT];

  always #5 clk = ~clk;

  vxlate_tlb #(.ENTRIES(ENT), .PPN_W(PPNW)) u_vxlate_tlb (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .privMode(privMode), .updValid(updValid),
    .updIndex(updIndex), .updVpn(updVpn), .updPpn(updPpn),
    .updPresent(updPresent), .updRead(updRead), .updWrite(updWrite),
    .flushAll(flushAll), .clearTouched(clearTouched), .rspValid(rspValid),
    .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault),
    .rspPaddr(rspPaddr), .rspWasTouched(rspWasTouched),
    .rspWasDirty(rspWasDirty), .privFault(privFault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock of stimulus; expected outputs come from the model.
  task automatic step(input string tag, input logic rv, input logic [31:0] va,
                      input logic wr, input logic pv, input logic uv,
                      input logic [IDXW-1:0] ui, input logic [19:0] uvpn,
                      input logic [PPNW-1:0] uppn, input logic up, input logic ur,
                      input logic uw, input logic fl, input logic ct);
    int   mi;
    logic eHit, eMiss, eFault, eT, eD, ePf, doLoad;
    logic [31:0] ePa;
    reqValid = rv; reqVaddr = va; reqWrite = wr; privMode = pv;
    updValid = uv; updIndex = ui; updVpn = uvpn; updPpn = uppn;
    updPresent = up; updRead = ur; updWrite = uw;
    flushAll = fl; clearTouched = ct;
    mi = -1;
    for (int i = ENT - 1; i >= 0; i--)
      if (mValid[i] && mVpn[i] == va[31:12]) mi = i;
    eHit = 0; eMiss = 0; eFault = 0; eT = 0; eD = 0; ePa = '0;
    if (rv) begin
      if (mi < 0) eMiss = 1;
      else if (wr ? mWr[mi] : mRd[mi]) begin
        eHit = 1; ePa = {mPpn[mi], va[11:0]}; eT = mTouch[mi]; eD = mDirty[mi];
      end else eFault = 1;
    end
    ePf = !pv && (uv || fl || ct);
    @(posedge clk);
    doLoad = pv && uv && !fl;
    for (int i = 0; i < ENT; i++) begin
      if (doLoad && ui == IDXW'(i)) begin
        mValid[i] = up; mVpn[i] = uvpn; mPpn[i] = uppn;
        mRd[i] = ur; mWr[i] = uw; mTouch[i] = 0; mDirty[i] = 0;
      end else begin
        mTouch[i] = (mTouch[i] && !(pv && ct)) || (eHit && mi == i);
        mDirty[i] = mDirty[i] || (eHit && wr && mi == i);
      end
      if (pv && fl) mValid[i] = 0;
    end
    @(negedge clk);
    chk({tag, " R1 R2 outcome"}, {28'd0, rspValid, rspHit, rspMiss, rspFault},
        {28'd0, rv, eHit, eMiss, eFault});
    chk({tag, " R3 paddr"}, rspPaddr, ePa);
    chk({tag, " R6 wasTouched"}, {31'd0, rspWasTouched}, {31'd0, eT});
    chk({tag, " R7 wasDirty"}, {31'd0, rspWasDirty}, {31'd0, eD});
    chk({tag, " R10 privFault"}, {31'd0, privFault}, {31'd0, ePf});
  endtask

  task automatic look(input string tag, input logic [31:0] va, input logic wr);
    step(tag, 1, va, wr, 1, 0, '0, '0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(input string tag, input logic [IDXW-1:0] ix, input logic [19:0] vp,
                      input logic [PPNW-1:0] pp, input logic pr, input logic r, input logic w);
    step(tag, 0, '0, 0, 1, 1, ix, vp, pp, pr, r, w, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'h1bad5eed);
    for (int i = 0; i < ENT; i++) begin
      mValid[i] = 0; mVpn[i] = '0; mPpn[i] = '0; mRd[i] = 0;
      mWr[i] = 0; mTouch[i] = 0; mDirty[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {27'd0, rspValid, rspHit, rspMiss, rspFault, privFault}, 32'd0);

    look("R4 empty", 32'h12345678, 0);
    load("R9 load0", 2'd0, 20'h12345, 20'hABCDE, 1, 1, 1);
    look("R9 R3 first hit", 32'h12345678, 0);
    look("R6 touched now", 32'h12345FFF, 0);
    look("R7 write hit", 32'h12345000, 1);
    look("R7 dirty seen", 32'h12345123, 0);
    load("R9 load1 ro", 2'd1, 20'h00001, 20'h00777, 1, 1, 0);
    look("R5 write to ro", 32'h00001ABC, 1);
    look("R5 flags kept", 32'h00001ABC, 0);
    load("R9 load2 wo", 2'd2, 20'h00002, 20'h00888, 1, 0, 1);
    look("R5 read of wo", 32'h00002000, 0);
    step("R6 clear", 0, '0, 0, 1, 0, '0, '0, '0, 0, 0, 0, 0, 1);
    look("R6 after clear", 32'h12345000, 0);
    step("R6 clear with hit", 1, 32'h00001000, 0, 1, 0, '0, '0, '0, 0, 0, 0, 0, 1);
    look("R6 kept by hit", 32'h00001000, 0);
    step("R10 user load", 0, '0, 0, 0, 1, 2'd3, 20'h0AAAA, 20'h00001, 1, 1, 1, 0, 0);
    look("R10 not loaded", 32'h0AAAA000, 0);
    step("R10 user flush", 0, '0, 0, 0, 0, '0, '0, '0, 0, 0, 0, 1, 0);
    look("R10 still mapped", 32'h12345000, 0);
    load("R11 dup", 2'd3, 20'h12345, 20'h11111, 1, 1, 1);
    look("R11 lowest wins", 32'h12345456, 0);
    step("R12 same cycle", 1, 32'h12345001, 0, 1, 1, 2'd0, 20'h12345, 20'h22222, 1, 1, 1, 0, 0);
    look("R12 new mapping", 32'h12345002, 0);
    load("R4 not present", 2'd2, 20'h00002, 20'h00888, 0, 1, 1);
    look("R4 absent entry", 32'h00002000, 0);
    step("R8 flush with load", 0, '0, 0, 1, 1, 2'd1, 20'h00005, 20'h00005, 1, 1, 1, 1, 0);
    look("R8 flushed", 32'h12345000, 0);
    look("R8 load dropped", 32'h00005000, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [19:0] vp;
      vp = 20'h00010 + 20'($urandom_range(0, 7));
      step("rand", ($urandom_range(0, 9) < 7), {vp, 12'($urandom)},
           1'($urandom), ($urandom_range(0, 9) != 0), ($urandom_range(0, 9) < 3),
           IDXW'($urandom), 20'h00010 + 20'($urandom_range(0, 7)), PPNW'($urandom),
           ($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 49) == 0), ($urandom_range(0, 19) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule